// File: doc/BRIEF.md
# Bidirectional GPIO Port with Data-Bus Takeover

This block is an eight-pin general-purpose I/O port sitting on a simple peripheral register bus. Software programs a direction byte and an output data byte and samples the pins through a synchronised input register. Two of the port's addresses are shared with neighbouring ports. A read at the direction address returns a neighbour's pin states, because the direction byte itself cannot be read back. A write at the input-register address is handed to a second neighbour as a direction-register write strobe.

When the chip runs in an expanded mode and the bus-width select leaves the port in data-bus duty, the eight pins carry the external data bus. In that state the bus controller supplies both the drive data and the drive enable, and the direction byte is ignored. Hardware standby clears the direction byte. Software standby keeps it. Both standby states, and reset, release every pad to high impedance.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset the direction byte and the output byte are 0x00. All pad output enables are low, and a read of the output address (0xFFBC) returns 0x00.
- R2: A write to 0xFFBC updates the output byte on the next clock edge. A read of 0xFFBC returns that byte.
- R3: The direction byte is written at 0xFFBE. A read of 0xFFBE returns the neighbour pin input `nbr_pins` and never the direction byte.
- R4: A write to 0xFFBD raises `nbr_dir_we` for that cycle, with the write data on `nbr_dir_wdata`. It leaves this port's own registers unchanged.
- R5: A read of 0xFFBD returns the pad levels captured through a two-stage synchronizer. A pad change becomes visible after the second rising edge and not after the first.
- R6: In port mode (`exp_en`=0, or `exp_en`=1 with `port_sel`=1), pin i is driven when direction bit i is 1. It drives output bit i.
- R7: In bus mode (`exp_en`=1 and `port_sel`=0), all pads carry `bus_dout`, and every output enable equals `bus_drive`, whatever the direction byte holds.
- R8: Asserting `hw_stby` clears the direction byte on the next edge and holds all output enables low.
- R9: During `sw_stby` all output enables are low and the direction byte is kept. Once `sw_stby` is released, the previous direction byte drives the pads again.
- R10: Register writes made during either standby state have no effect. This includes the neighbour strobe.
- R11: In bus mode, output enables stay low during standby even with `bus_drive` high.
- R12: An access to any other address changes no register, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| exp_en | input | 1 | Expanded-mode enable |
| port_sel | input | 1 | Bus-width select: 1 keeps the pins as a port, 0 gives them to the data bus |
| reg_addr | input | 16 | Register address (low 16 bits) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| nbr_pins | input | 8 | Neighbour port pin states |
| nbr_dir_we | output | 1 | Neighbour direction write strobe |
| nbr_dir_wdata | output | 8 | Neighbour direction write data |
| bus_drive | input | 1 | Bus controller drive enable |
| bus_dout | input | 8 | Bus controller write data |
| bus_din | output | 8 | Raw pad levels to the bus controller |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |

## Verification
The assertions assume that a write strobe is a single-cycle request with its address stable across that edge. They also assume that the standby inputs change only at clock edges, so each standby effect lands on a known edge. The bench drives every input on the falling edge, raises each write strobe for exactly one cycle, and never overlaps reads with writes. Mode and standby changes are made only between accesses.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dout;
    } port_regs_t;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFFBE,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 16'hFFBC,
    parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFFBD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] dout_q,
    output logic              fwd_we,
    output logic [PORT_W-1:0] fwd_wdata
);
    port_regs_t regs_d, regs_q;
    logic       wr_ok;

    always_comb begin
        regs_d = regs_q;
        wr_ok  = wr && !hw_stby && !sw_stby;
        if (hw_stby) begin
            regs_d.dir = '0;
        end else if (wr_ok) begin
            if (addr == DIR_ADDR) regs_d.dir  = wdata;
            if (addr == OUT_ADDR) regs_d.dout = wdata;
        end
        fwd_we    = wr_ok && (addr == PIN_ADDR);
        fwd_wdata = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dir_q  = regs_q.dir;
    assign dout_q = regs_q.dout;

    // R8
    p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> dir_q == '0);
    // R9
    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(dir_q));
    // R4
    p_alias_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == PIN_ADDR && !hw_stby) |=> ($stable(dir_q) && $stable(dout_q)));
    // R2
    p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OUT_ADDR && !hw_stby && !sw_stby) |=> dout_q == $past(wdata));
    // R10
    p_stby_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_we |-> (wr && !sw_stby && !hw_stby));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) stage_q[g] <= stage_d[g];
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_port_pkg::*;
(
    input  logic              hiz,
    input  logic              bus_mode,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] dout,
    input  logic              bus_drive,
    input  logic [PORT_W-1:0] bus_dout,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    always_comb begin
        if (bus_mode) begin
            pad_out = bus_dout;
            pad_oe  = {PORT_W{bus_drive}};
        end else begin
            pad_out = dout;
            pad_oe  = dir;
        end
        if (hiz) pad_oe = '0;
    end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFFBE,
    parameter logic [ADDR_W-1:0] OUT_ADDR    = 16'hFFBC,
    parameter logic [ADDR_W-1:0] PIN_ADDR    = 16'hFFBD,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              exp_en,
    input  logic              port_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] nbr_pins,
    output logic              nbr_dir_we,
    output logic [PORT_W-1:0] nbr_dir_wdata,
    input  logic              bus_drive,
    input  logic [PORT_W-1:0] bus_dout,
    output logic [PORT_W-1:0] bus_din,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    logic [PORT_W-1:0] dir_q, dout_q, pins_sync;
    logic              bus_mode, hiz;

    gpio_port_regs #(
        .DIR_ADDR(DIR_ADDR), .OUT_ADDR(OUT_ADDR), .PIN_ADDR(PIN_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .dir_q(dir_q), .dout_q(dout_q),
        .fwd_we(nbr_dir_we), .fwd_wdata(nbr_dir_wdata)
    );

    gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .async_in(pad_in), .sync_out(pins_sync)
    );

    assign bus_mode = exp_en && !port_sel;
    assign hiz      = !rst_n || hw_stby || sw_stby;
    assign bus_din  = pad_in;

    gpio_pad_mux u_mux (
        .hiz(hiz), .bus_mode(bus_mode), .dir(dir_q), .dout(dout_q),
        .bus_drive(bus_drive), .bus_dout(bus_dout),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                DIR_ADDR: reg_rdata = nbr_pins;
                OUT_ADDR: reg_rdata = dout_q;
                PIN_ADDR: reg_rdata = pins_sync;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R11
    p_stby_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby || sw_stby) |-> pad_oe == '0);
    // R8: one edge after a hardware standby request the port drives nothing in port mode
    p_hw_port_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stby && !bus_mode) |=> (bus_mode || pad_oe == '0));
endmodule

// File: tb/test_gpio_bus_port.sv
module test_gpio_bus_port;
    logic        clk = 0, rst_n = 0;
    logic        hw_stby = 0, sw_stby = 0, exp_en = 0, port_sel = 0;
    logic [15:0] reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_wdata = 0, reg_rdata, nbr_pins = 0;
    logic        nbr_dir_we;
    logic [7:0]  nbr_dir_wdata;
    logic        bus_drive = 0;
    logic [7:0]  bus_dout = 0, bus_din, pad_in = 0, pad_out, pad_oe;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    localparam logic [15:0] A_DIR = 16'hFFBE, A_OUT = 16'hFFBC, A_PIN = 16'hFFBD;

    gpio_bus_port i_gpio_bus_port (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .exp_en(exp_en), .port_sel(port_sel), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nbr_pins(nbr_pins), .nbr_dir_we(nbr_dir_we),
        .nbr_dir_wdata(nbr_dir_wdata), .bus_drive(bus_drive), .bus_dout(bus_dout),
        .bus_din(bus_din), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #10 clk = ~clk;

    // {exp_en, port_sel, bus_drive, dir, dout, bus_dout, exp_oe, exp_out}
    localparam int NV = 6;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hFF, 8'hA5, 8'h3C},
        {1'b1, 1'b1, 1'b0, 8'h0F, 8'h55, 8'h00, 8'h0F, 8'h55},
        {1'b1, 1'b0, 1'b1, 8'h0F, 8'h55, 8'hC3, 8'hFF, 8'hC3},
        {1'b1, 1'b0, 1'b0, 8'hFF, 8'h12, 8'h99, 8'h00, 8'h99},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h77, 8'h00, 8'hFF},
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'hAA, 8'hFF, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    initial begin
        #2_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        #1 check("R1 oe in reset", pad_oe, 8'h00);
        rst_n = 1;
        @(negedge clk);
        #1 check("R1 oe after reset", pad_oe, 8'h00);
        rd_reg(A_OUT, r); check("R1 out reg", r, 8'h00);

        // vector table: R6 port mode, R7 bus mode, R2 readback
        for (int i = 0; i < NV; i++) begin
            wr_reg(A_DIR, VEC[i][39:32]);
            wr_reg(A_OUT, VEC[i][31:24]);
            @(negedge clk);
            exp_en = VEC[i][42]; port_sel = VEC[i][41]; bus_drive = VEC[i][40];
            bus_dout = VEC[i][23:16];
            #1;
            check((VEC[i][42] && !VEC[i][41]) ? "R7 oe" : "R6 oe", pad_oe, VEC[i][15:8]);
            check((VEC[i][42] && !VEC[i][41]) ? "R7 out" : "R6 out", pad_out, VEC[i][7:0]);
            rd_reg(A_OUT, r); check("R2 readback", r, VEC[i][31:24]);
        end
        exp_en = 0; port_sel = 0; bus_drive = 0;

        // R3: direction address reads neighbour pins
        wr_reg(A_DIR, 8'h33);
        nbr_pins = 8'h5A;
        rd_reg(A_DIR, r); check("R3 alias read", r, 8'h5A);
        #1 check("R3 dir intact", pad_oe, 8'h33);

        // R4: write to pin address goes to neighbour
        wr_reg(A_OUT, 8'h44);
        @(negedge clk);
        reg_addr = A_PIN; reg_wdata = 8'h81; reg_wr = 1;
        #1 check("R4 strobe", {7'd0, nbr_dir_we}, 8'h01);
        check("R4 data", nbr_dir_wdata, 8'h81);
        @(negedge clk); reg_wr = 0;
        #1 check("R4 strobe ends", {7'd0, nbr_dir_we}, 8'h00);
        check("R4 dir kept", pad_oe, 8'h33);
        check("R4 out kept", pad_out, 8'h44);

        // R5: two-stage synchronizer
        @(negedge clk); pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hC6;
        rd_reg(A_PIN, r); check("R5 one edge", r, 8'h00);
        rd_reg(A_PIN, r); check("R5 two edges", r, 8'hC6);
        check("R5 bus_din", bus_din, 8'hC6);

        // R12: unknown address
        wr_reg(16'h1234, 8'hEE);
        rd_reg(16'h1234, r); check("R12 read zero", r, 8'h00);
        rd_reg(A_OUT, r); check("R12 out kept", r, 8'h44);
        #1 check("R12 dir kept", pad_oe, 8'h33);

        // R9/R10: software standby
        wr_reg(A_DIR, 8'h3C);
        @(negedge clk); sw_stby = 1;
        #1 check("R9 sw hiz", pad_oe, 8'h00);
        wr_reg(A_DIR, 8'hFF);
        wr_reg(A_OUT, 8'h11);
        @(negedge clk);
        reg_addr = A_PIN; reg_wr = 1; reg_wdata = 8'h22;
        #1 check("R10 no strobe", {7'd0, nbr_dir_we}, 8'h00);
        @(negedge clk); reg_wr = 0;
        sw_stby = 0;
        #1 check("R9 dir kept", pad_oe, 8'h3C);
        rd_reg(A_OUT, r); check("R10 out kept", r, 8'h44);

        // R8: hardware standby clears direction
        wr_reg(A_DIR, 8'hFF);
        @(negedge clk); hw_stby = 1;
        #1 check("R8 hw hiz", pad_oe, 8'h00);
        @(negedge clk); hw_stby = 0;
        #1 check("R8 dir cleared", pad_oe, 8'h00);

        // R11: bus mode in standby
        @(negedge clk);
        exp_en = 1; port_sel = 0; bus_drive = 1; bus_dout = 8'h5C;
        #1 check("R11 bus drives", pad_oe, 8'hFF);
        @(negedge clk); sw_stby = 1;
        #1 check("R11 bus hiz", pad_oe, 8'h00);
        check("R11 bus data", pad_out, 8'h5C);
        @(negedge clk); sw_stby = 0;
        #1 check("R11 bus back", pad_oe, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule